// File: doc/BRIEF.md
# Three-Code Sequential Combination Lock

The block is a small controller that releases a lock only after three code values are entered in the correct order. It does not store or compare the codes itself. It drives a 2-bit select, `code_sel`, that tells an outside multiplexer which stored code goes to an outside comparator. The comparator returns `entry_match`. The user's keypad logic pulses `entry_strobe` for one cycle each time a fresh value has been entered.

The controller has five named states. FIRST, SECOND and THIRD wait for the first, second and third code. OPEN means the lock is released. ERR means a wrong value was entered. The transitions are:

- **advance**: strobe with match. FIRST goes to SECOND, SECOND to THIRD, and THIRD to OPEN.
- **reject**: strobe without match in any waiting state. The machine goes to ERR.
- **idle**: no strobe. The machine stays where it is.
- **restart**: reset. Every state goes to FIRST.

OPEN and ERR are held until reset. Reset is synchronous and active high. Both outputs depend on the state only, so they change just after the clock edge that changes the state.

Top module: `seq_code_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine goes to FIRST. After that edge, `code_sel` is 2'd0 and `unlocked` is 0.
- R2: In FIRST, SECOND and THIRD, `code_sel` is 2'd0, 2'd1 and 2'd2 respectively, and `unlocked` is 0.
- R3: An edge with `entry_strobe`=1 and `entry_match`=1 moves FIRST to SECOND, SECOND to THIRD and THIRD to OPEN.
- R4: An edge with `entry_strobe`=1 and `entry_match`=0 in FIRST, SECOND or THIRD moves the machine to ERR. In ERR, `code_sel` is 2'd3 and `unlocked` is 0.
- R5: An edge with `entry_strobe`=0 leaves the state unchanged, whatever the value of `entry_match`.
- R6: `unlocked` is 1 only in OPEN. In OPEN, `code_sel` is 2'd3.
- R7: Once in OPEN, the machine stays in OPEN under any strobe or match input until reset.
- R8: Once in ERR, the machine stays in ERR under any strobe or match input, including a correct entry, until reset.
- R9: Reset takes precedence over the inputs. A reset edge returns OPEN or ERR to FIRST, even if `entry_strobe` and `entry_match` are both high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| entry_strobe | input | 1 | One-cycle pulse marking a fresh entered value |
| entry_match | input | 1 | Comparator result: the entry equals the selected code |
| code_sel | output | 2 | Selects code 0, 1 or 2; 3 when no code is compared |
| unlocked | output | 1 | 1 while the lock is released |

## Verification
The bench enters a wrong value at each of the three positions. A design that missed a mismatch in a later state would let that entry through, or would fall back to the start instead of holding in ERR. It inserts idle cycles with `entry_match` high between strobes, which catches a design that advances on the match flag alone. It strobes correct entries after reaching ERR and after reaching OPEN, which exposes a design that can leave either state without reset. It also asserts reset together with a valid strobe, which catches reset having lower priority than the inputs.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [2:0] {
        ST_FIRST  = 3'd0,
        ST_SECOND = 3'd1,
        ST_THIRD  = 3'd2,
        ST_OPEN   = 3'd3,
        ST_ERR    = 3'd4
    } lock_state_t;

    localparam logic [SEL_W-1:0] SEL_CODE0 = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_CODE1 = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_CODE2 = SEL_W'(2);
    localparam logic [SEL_W-1:0] SEL_NONE  = {SEL_W{1'b1}};

endpackage

// File: rtl/lock_next_state.sv
module lock_next_state
    import lock_pkg::*;
(
    input  lock_state_t cur_state,
    input  logic        strobe,
    input  logic        match,
    output lock_state_t nxt_state
);

    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_FIRST: begin
                if (strobe) nxt_state = match ? ST_SECOND : ST_ERR;
            end
            ST_SECOND: begin
                if (strobe) nxt_state = match ? ST_THIRD : ST_ERR;
            end
            ST_THIRD: begin
                if (strobe) nxt_state = match ? ST_OPEN : ST_ERR;
            end
            ST_OPEN:  nxt_state = ST_OPEN;
            ST_ERR:   nxt_state = ST_ERR;
            default:  nxt_state = ST_ERR;
        endcase
    end

endmodule

// File: rtl/lock_out_decode.sv
module lock_out_decode
    import lock_pkg::*;
(
    input  lock_state_t       cur_state,
    output logic [SEL_W-1:0]  sel,
    output logic              release_o
);

    always_comb begin
        sel       = SEL_NONE;
        release_o = 1'b0;
        unique case (cur_state)
            ST_FIRST:  sel = SEL_CODE0;
            ST_SECOND: sel = SEL_CODE1;
            ST_THIRD:  sel = SEL_CODE2;
            ST_OPEN: begin
                sel       = SEL_NONE;
                release_o = 1'b1;
            end
            ST_ERR:    sel = SEL_NONE;
            default: begin
                sel       = SEL_NONE;
                release_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/seq_code_lock.sv
module seq_code_lock
    import lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             entry_strobe,
    input  logic             entry_match,
    output logic [SEL_W-1:0] code_sel,
    output logic             unlocked
);

    lock_state_t state_q;
    lock_state_t state_d;

    lock_next_state u_next (
        .cur_state (state_q),
        .strobe    (entry_strobe),
        .match     (entry_match),
        .nxt_state (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FIRST;
        else     state_q <= state_d;
    end

    lock_out_decode u_out (
        .cur_state (state_q),
        .sel       (code_sel),
        .release_o (unlocked)
    );

endmodule

// File: rtl/lock_checker.sv
module lock_checker
    import lock_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             strobe,
    input logic             match,
    input logic [SEL_W-1:0] sel,
    input logic             unl
);

    // R1: reset lands in the first waiting state
    a_r1_reset_first: assert property (@(posedge clk)
        rst |=> (sel == SEL_CODE0 && !unl));

    // R3: a correct entry moves one step forward
    a_r3_advance_first: assert property (@(posedge clk) disable iff (rst)
        (strobe && match && sel == SEL_CODE0) |=> (sel == SEL_CODE1));

    a_r3_advance_last: assert property (@(posedge clk) disable iff (rst)
        (strobe && match && sel == SEL_CODE2) |=> unl);

    // R4: a wrong entry while waiting leads to the error state
    a_r4_reject: assert property (@(posedge clk) disable iff (rst)
        (strobe && !match && sel != SEL_NONE) |=> (sel == SEL_NONE && !unl));

    // R5: no strobe, no change
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(sel) && $stable(unl)));

    // R6: released only with no code selected
    a_r6_open_sel: assert property (@(posedge clk) disable iff (rst)
        unl |-> (sel == SEL_NONE));

    // R7: open is held
    a_r7_open_sticky: assert property (@(posedge clk) disable iff (rst)
        unl |=> unl);

    // R8: error is held
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE && !unl) |=> (sel == SEL_NONE && !unl));

endmodule

bind seq_code_lock lock_checker u_lock_checker (
    .clk    (clk),
    .rst    (rst),
    .strobe (entry_strobe),
    .match  (entry_match),
    .sel    (code_sel),
    .unl    (unlocked)
);

// File: tb/test_seq_code_lock.sv
`timescale 1ns/1ps
module test_seq_code_lock;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       entry_strobe = 1'b0;
    logic       entry_match = 1'b0;
    logic [1:0] code_sel;
    logic       unlocked;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    seq_code_lock i_seq_code_lock (
        .clk          (clk),
        .rst          (rst),
        .entry_strobe (entry_strobe),
        .entry_match  (entry_match),
        .code_sel     (code_sel),
        .unlocked     (unlocked)
    );

    // each row: {rst, strobe, match, expected sel[1:0], expected unlocked}
    localparam int NV = 21;
    localparam logic [5:0] VEC [NV] = '{
        6'b1_0_0_00_0, // R1 reset
        6'b0_0_1_00_0, // R5 idle, match high
        6'b0_1_1_01_0, // R3 R2 first -> second
        6'b0_0_0_01_0, // R5 idle
        6'b0_1_1_10_0, // R3 R2 second -> third
        6'b0_0_1_10_0, // R5 idle
        6'b0_1_1_11_1, // R3 R6 third -> open
        6'b0_1_0_11_1, // R7 wrong entry in open
        6'b0_1_1_11_1, // R7 right entry in open
        6'b1_0_0_00_0, // R9 reset from open
        6'b0_1_0_11_0, // R4 wrong at position one
        6'b0_1_1_11_0, // R8 correct entry ignored in error
        6'b1_0_0_00_0, // R9 reset from error
        6'b0_1_1_01_0, // R3
        6'b0_1_0_11_0, // R4 wrong at position two
        6'b1_0_0_00_0, // R1
        6'b0_1_1_01_0, // R3
        6'b0_1_1_10_0, // R3
        6'b0_1_0_11_0, // R4 wrong at position three
        6'b0_0_1_11_0, // R8 idle in error
        6'b1_1_1_00_0  // R9 reset beats a valid strobe
    };

    task automatic check(input string tag, input logic [1:0] sel_exp, input logic unl_exp);
        total++;
        if (code_sel !== sel_exp || unlocked !== unl_exp) begin
            bad++;
            $display("FAIL %s: sel=%0d unlocked=%0b expected sel=%0d unlocked=%0b",
                     tag, code_sel, unlocked, sel_exp, unl_exp);
        end
    endtask

    task automatic step(input logic r, input logic s, input logic m);
        @(negedge clk);
        rst = r; entry_strobe = s; entry_match = m;
        @(posedge clk);
        @(negedge clk);
        entry_strobe = 1'b0;
        entry_match  = 1'b0;
        rst          = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3]);
            check($sformatf("table row %0d", i), VEC[i][2:1], VEC[i][0]);
        end

        // R1: reset held several cycles with inputs active
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        check("R1 long reset", 2'd0, 1'b0);

        // R2: select follows each waiting state
        check("R2 first", 2'd0, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        check("R2 second", 2'd1, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        check("R2 third", 2'd2, 1'b0);

        // R5: long idle stretch in THIRD with match toggling
        for (int k = 0; k < 6; k++) step(1'b0, 1'b0, k[0]);
        check("R5 long idle", 2'd2, 1'b0);

        // R6 R7: open, then many strobes
        step(1'b0, 1'b1, 1'b1);
        check("R6 open", 2'd3, 1'b1);
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1, k[1]);
        check("R7 open held", 2'd3, 1'b1);

        // R9 then R4 R8: error reached, full correct sequence ignored
        step(1'b1, 1'b0, 1'b0);
        check("R9 reset", 2'd0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        check("R4 reject", 2'd3, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b1);
        check("R8 error held", 2'd3, 1'b0);

        finish_run();
    end

endmodule